// File: doc/BRIEF.md
# Sequential Multiply/Divide Unit with Shared High/Low Result Registers

This block is an iterative integer arithmetic unit. It multiplies or divides two 32-bit operands, signed or unsigned, and resolves one bit of the result per clock cycle. A single 64-bit working register and one 32-bit operand register serve every operation. A multiply shifts the working register right and conditionally adds the multiplicand. A divide shifts it left and performs a restoring subtract of the divisor.

Signed operations run on operand magnitudes. The operand signs are saved at start. One extra cycle at the end applies the sign correction, and that cycle writes both result registers at once. Every result lands in a high/low pair of 32-bit registers. For a multiply, the pair holds the 64-bit product. For a divide, the high half holds the remainder and the low half holds the quotient. The pair keeps its value until the next operation completes.

A client pulses `start_i` while the unit is idle. It then waits for the one-cycle `done_o` pulse and reads `hi_o` and `lo_o`.

Top module: `muldiv_seq`

## Requirements
- R1: While `rst` is high and in the first cycle after it falls, `busy_o`, `done_o`, `hi_o` and `lo_o` are all zero.
- R2: `op_i` selects the operation: 2'b00 signed multiply, 2'b01 unsigned multiply, 2'b10 signed divide, 2'b11 unsigned divide. A `start_i` sampled high while `busy_o` is low is accepted, and `busy_o` is high in the next cycle.
- R3: For an accepted start sampled at clock edge E, `busy_o` is high for the 33 cycles after E. `done_o` is high for exactly one cycle, the 34th cycle after E, during which `busy_o` is low.
- R4: A `start_i` that arrives while `busy_o` is high is ignored. The running operation keeps its operands and its latency.
- R5: An unsigned multiply leaves the 64-bit product of the two operands, viewed as unsigned, with bits 63:32 in `hi_o` and bits 31:0 in `lo_o`.
- R6: A signed multiply leaves the 64-bit two's complement product of the two operands in `hi_o`:`lo_o`.
- R7: An unsigned divide with a non-zero divisor leaves the quotient a/b in `lo_o` and the remainder in `hi_o`. The remainder is less than b.
- R8: A signed divide with a non-zero divisor leaves a quotient truncated toward zero in `lo_o` and a remainder carrying the dividend's sign in `hi_o`. The two satisfy a = q·b + r.
- R9: A divide by zero, signed or unsigned, completes with the normal latency. It leaves all ones in `lo_o` and the unchanged dividend in `hi_o`.
- R10: `hi_o` and `lo_o` change only in a cycle where `done_o` is high. Operand changes without an accepted start leave them untouched.
- R11: A signed divide of 32'h80000000 by 32'hFFFFFFFF leaves quotient 32'h80000000 and remainder 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Start strobe, taken only while idle |
| op_i | input | 2 | Operation select (see R2) |
| a_i | input | 32 | Multiplicand or dividend |
| b_i | input | 32 | Multiplier or divisor |
| busy_o | output | 1 | An operation is in progress |
| done_o | output | 1 | One-cycle completion pulse |
| hi_o | output | 32 | Product upper half, or remainder |
| lo_o | output | 32 | Product lower half, or quotient |

## Verification
On every cycle, the assertions check the following:
- the completion pulse is single and arrives after exactly 33 busy cycles;
- `busy_o` rises only after a start;
- the result pair moves only at completion;
- each completed result is arithmetically consistent with the operands captured at acceptance: the exact product, q·b + r equal to a with a bounded unsigned remainder, and the all-ones/dividend pattern on a zero divisor.

Only the bench's scenarios can show the rest: the reset values, that a start injected mid-run does not disturb the result, that truncation direction and remainder sign match for each sign combination of a signed divide, and the single overflowing signed quotient.

// File: rtl/muldiv_pkg.sv
package muldiv_pkg;

  typedef enum logic [1:0] {
    OP_MULS = 2'b00,
    OP_MULU = 2'b01,
    OP_DIVS = 2'b10,
    OP_DIVU = 2'b11
  } md_op_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIX  = 2'd2
  } md_state_e;

endpackage

// File: rtl/muldiv_mag.sv
// Converts an operand to its magnitude and reports whether it was negative.
module muldiv_mag #(
  parameter int W = 32
) (
  input  logic [W-1:0] val_i,
  input  logic         sgn_i,
  output logic [W-1:0] mag_o,
  output logic         neg_o
);
  always_comb begin
    neg_o = sgn_i & val_i[W-1];
    mag_o = neg_o ? (~val_i + W'(1)) : val_i;
  end
endmodule

// File: rtl/muldiv_ctrl.sv
// Sequencer: idle, ITER iteration cycles, one sign-fix cycle.
module muldiv_ctrl
  import muldiv_pkg::*;
#(
  parameter int ITER = 32
) (
  input  logic clk,
  input  logic rst,
  input  logic start_i,
  output logic load_o,
  output logic step_o,
  output logic fix_o,
  output logic busy_o,
  output logic done_o
);
  localparam int CW = (ITER > 1) ? $clog2(ITER) : 1;

  md_state_e     state_q;
  logic [CW-1:0] cnt_q;

  assign load_o = (state_q == ST_IDLE) && start_i;
  assign step_o = (state_q == ST_RUN);
  assign fix_o  = (state_q == ST_FIX);
  assign busy_o = (state_q != ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      done_o  <= 1'b0;
    end else begin
      done_o <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            state_q <= ST_RUN;
            cnt_q   <= '0;
          end
        end
        ST_RUN: begin
          if (cnt_q == CW'(ITER - 1)) state_q <= ST_FIX;
          cnt_q <= cnt_q + CW'(1);
        end
        ST_FIX: begin
          state_q <= ST_IDLE;
          done_o  <= 1'b1;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/muldiv_core.sv
// Shared iteration datapath: right shift-and-add or left restoring shift-and-subtract.
module muldiv_core #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load_i,
  input  logic         step_i,
  input  logic         ld_div_i,
  input  logic         run_div_i,
  input  logic [W-1:0] mag_a_i,
  input  logic [W-1:0] mag_b_i,
  output logic [2*W-1:0] work_o
);
  logic [2*W-1:0] work_q;
  logic [W-1:0]   opnd_q;

  logic [W:0]     add_sum;
  logic [W:0]     top_sh;
  logic [W+1:0]   diff;
  logic [2*W-1:0] nxt_mul;
  logic [2*W-1:0] nxt_div;

  always_comb begin
    // multiply step: conditional add into the upper half, then shift right
    add_sum = {1'b0, work_q[2*W-1:W]} + (work_q[0] ? {1'b0, opnd_q} : '0);
    nxt_mul = {add_sum, work_q[W-1:1]};
    // divide step: shift left, trial subtract, keep or restore
    top_sh  = work_q[2*W-1:W-1];
    diff    = {1'b0, top_sh} - {2'b00, opnd_q};
    if (!diff[W+1]) nxt_div = {diff[W-1:0], work_q[W-2:0], 1'b1};
    else            nxt_div = {top_sh[W-1:0], work_q[W-2:0], 1'b0};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      work_q <= '0;
      opnd_q <= '0;
    end else if (load_i) begin
      work_q <= {{W{1'b0}}, (ld_div_i ? mag_a_i : mag_b_i)};
      opnd_q <= ld_div_i ? mag_b_i : mag_a_i;
    end else if (step_i) begin
      work_q <= run_div_i ? nxt_div : nxt_mul;
    end
  end

  assign work_o = work_q;
endmodule

// File: rtl/muldiv_seq.sv
module muldiv_seq
  import muldiv_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start_i,
  input  logic [1:0]   op_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic         busy_o,
  output logic         done_o,
  output logic [W-1:0] hi_o,
  output logic [W-1:0] lo_o
);
  md_op_e op_e;
  logic   in_sgn, in_div;

  assign op_e   = md_op_e'(op_i);
  assign in_sgn = (op_e == OP_MULS) || (op_e == OP_DIVS);
  assign in_div = (op_e == OP_DIVS) || (op_e == OP_DIVU);

  logic [W-1:0] mag_a, mag_b;
  logic         neg_a, neg_b;

  muldiv_mag #(.W(W)) u_mag_a (.val_i(a_i), .sgn_i(in_sgn), .mag_o(mag_a), .neg_o(neg_a));
  muldiv_mag #(.W(W)) u_mag_b (.val_i(b_i), .sgn_i(in_sgn), .mag_o(mag_b), .neg_o(neg_b));

  logic load, step, fix;

  muldiv_ctrl #(.ITER(W)) u_ctrl (
    .clk(clk), .rst(rst), .start_i(start_i),
    .load_o(load), .step_o(step), .fix_o(fix),
    .busy_o(busy_o), .done_o(done_o)
  );

  logic div_q, sgn_q, neg_a_q, neg_b_q, bzero_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      div_q   <= 1'b0;
      sgn_q   <= 1'b0;
      neg_a_q <= 1'b0;
      neg_b_q <= 1'b0;
      bzero_q <= 1'b0;
    end else if (load) begin
      div_q   <= in_div;
      sgn_q   <= in_sgn;
      neg_a_q <= neg_a;
      neg_b_q <= neg_b;
      bzero_q <= (b_i == '0);
    end
  end

  logic [2*W-1:0] work;

  muldiv_core #(.W(W)) u_core (
    .clk(clk), .rst(rst), .load_i(load), .step_i(step),
    .ld_div_i(in_div), .run_div_i(div_q),
    .mag_a_i(mag_a), .mag_b_i(mag_b), .work_o(work)
  );

  // sign correction applied in the fix cycle
  logic [2*W-1:0] prod;
  logic [W-1:0]   quo, rem, res_hi, res_lo;

  always_comb begin
    prod = (sgn_q && (neg_a_q ^ neg_b_q)) ? (~work + (2*W)'(1)) : work;
    quo  = work[W-1:0];
    rem  = work[2*W-1:W];
    if (sgn_q && (neg_a_q ^ neg_b_q) && !bzero_q) quo = ~quo + W'(1);
    if (sgn_q && neg_a_q)                         rem = ~rem + W'(1);
    if (div_q) begin
      res_hi = rem;
      res_lo = quo;
    end else begin
      res_hi = prod[2*W-1:W];
      res_lo = prod[W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hi_o <= '0;
      lo_o <= '0;
    end else if (fix) begin
      hi_o <= res_hi;
      lo_o <= res_lo;
    end
  end
endmodule

// File: rtl/muldiv_seq_chk.sv
module muldiv_seq_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst,
  input logic         start_i,
  input logic [1:0]   op_i,
  input logic [W-1:0] a_i,
  input logic [W-1:0] b_i,
  input logic         busy_o,
  input logic         done_o,
  input logic [W-1:0] hi_o,
  input logic [W-1:0] lo_o
);
  localparam int CW = $clog2(W + 2) + 1;

  logic [1:0]   cap_op;
  logic [W-1:0] cap_a, cap_b;
  logic [CW-1:0] run_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cap_op  <= '0;
      cap_a   <= '0;
      cap_b   <= '0;
      run_cnt <= '0;
    end else begin
      if (start_i && !busy_o) begin
        cap_op <= op_i;
        cap_a  <= a_i;
        cap_b  <= b_i;
      end
      run_cnt <= busy_o ? run_cnt + CW'(1) : '0;
    end
  end

  logic [2*W-1:0] p_u, p_s;
  always_comb begin
    p_u = {{W{1'b0}}, cap_a} * {{W{1'b0}}, cap_b};
    p_s = {{W{cap_a[W-1]}}, cap_a} * {{W{cap_b[W-1]}}, cap_b};
  end

  a_r3_done_single: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);
  a_r3_latency: assert property (@(posedge clk) disable iff (rst)
    done_o |-> (run_cnt == CW'(W + 1)) && !busy_o);
  a_r2_accept: assert property (@(posedge clk) disable iff (rst)
    $rose(busy_o) |-> $past(start_i));
  a_r5_r6_product: assert property (@(posedge clk) disable iff (rst)
    (done_o && !cap_op[1]) |-> ({hi_o, lo_o} == (cap_op[0] ? p_u : p_s)));
  a_r8_div_identity: assert property (@(posedge clk) disable iff (rst)
    (done_o && cap_op[1] && cap_b != '0) |-> (W'(lo_o * cap_b + hi_o) == cap_a));
  a_r7_rem_bound: assert property (@(posedge clk) disable iff (rst)
    (done_o && cap_op == 2'b11 && cap_b != '0) |-> (hi_o < cap_b));
  a_r9_div_zero: assert property (@(posedge clk) disable iff (rst)
    (done_o && cap_op[1] && cap_b == '0) |-> (lo_o == '1 && hi_o == cap_a));
  a_r10_hold: assert property (@(posedge clk) disable iff (rst)
    !done_o |-> ($stable(hi_o) && $stable(lo_o)));
endmodule

bind muldiv_seq muldiv_seq_chk #(.W(W)) u_chk (
  .clk(clk), .rst(rst), .start_i(start_i), .op_i(op_i), .a_i(a_i), .b_i(b_i),
  .busy_o(busy_o), .done_o(done_o), .hi_o(hi_o), .lo_o(lo_o)
);

// File: tb/test_muldiv_seq.sv
`timescale 1ns/1ps
module test_muldiv_seq;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [1:0]  op = 2'b00;
  logic [31:0] a = '0, b = '0;
  logic        busy, done;
  logic [31:0] hi, lo;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  muldiv_seq #(.W(32)) i_muldiv_seq (
    .clk(clk), .rst(rst), .start_i(start), .op_i(op), .a_i(a), .b_i(b),
    .busy_o(busy), .done_o(done), .hi_o(hi), .lo_o(lo)
  );

  localparam int NV = 16;
  localparam logic [65:0] VEC [NV] = '{
    {2'b01, 32'd7,          32'd6},
    {2'b01, 32'hFFFFFFFF,   32'hFFFFFFFF},
    {2'b01, 32'h12345678,   32'h9ABCDEF0},
    {2'b00, 32'hFFFFFFFD,   32'd5},
    {2'b00, 32'hFFFFFFF9,   32'hFFFFFFF7},
    {2'b00, 32'h80000000,   32'h80000000},
    {2'b00, 32'h7FFFFFFF,   32'h80000000},
    {2'b11, 32'd7,          32'd2},
    {2'b11, 32'd100,        32'd7},
    {2'b11, 32'hFFFFFFFF,   32'd1},
    {2'b11, 32'd5,          32'd9},
    {2'b10, 32'hFFFFFFF9,   32'd2},
    {2'b10, 32'd7,          32'hFFFFFFFE},
    {2'b10, 32'hFFFFFFF9,   32'hFFFFFFFE},
    {2'b10, 32'h80000000,   32'hFFFFFFFF},
    {2'b11, 32'hDEADBEEF,   32'h00010000}
  };

  // reference: {hi, lo}
  function automatic logic [63:0] model(input logic [1:0] o, input logic [31:0] x, input logic [31:0] y);
    longint sx = longint'($signed(x));
    longint sy = longint'($signed(y));
    longint ux = longint'({32'b0, x});
    longint uy = longint'({32'b0, y});
    longint q, r;
    logic [63:0] p;
    if (o[1] && y == '0) return {x, 32'hFFFFFFFF};
    case (o)
      2'b00: begin p = 64'(sx * sy); return p; end
      2'b01: begin p = {32'b0, x} * {32'b0, y}; return p; end
      2'b10: begin q = sx / sy; r = sx % sy; return {r[31:0], q[31:0]}; end
      default: begin q = ux / uy; r = ux % uy; return {r[31:0], q[31:0]}; end
    endcase
  endfunction

  function automatic string tag_of(input logic [1:0] o, input logic [31:0] x, input logic [31:0] y);
    if (o == 2'b10 && x == 32'h80000000 && y == 32'hFFFFFFFF) return "R11";
    if (o[1] && y == '0) return "R9";
    case (o)
      2'b00: return "R6";
      2'b01: return "R5";
      2'b10: return "R8";
      default: return "R7";
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // runs one operation; optionally injects a competing start mid-run (R4)
  task automatic run_op(input logic [1:0] o, input logic [31:0] x, input logic [31:0] y,
                        input bit inject, input string req);
    int k;
    logic [63:0] exp;
    exp = model(o, x, y);
    @(negedge clk);
    op = o; a = x; b = y; start = 1'b1;
    k = 0;
    while (k < 60) begin
      @(negedge clk);
      k++;
      if (k == 1) begin
        start = 1'b0;
        chk(busy == 1'b1, "R2", {63'b0, busy}, 64'd1);
      end
      if (inject && k == 5) begin
        op = 2'b01; a = 32'd3; b = 32'd3; start = 1'b1;
      end
      if (inject && k == 6) begin
        start = 1'b0;
        chk(busy == 1'b1, "R4", {63'b0, busy}, 64'd1);
      end
      if (done) break;
    end
    chk(k == 34, "R3", 64'(k), 64'd34);
    chk({hi, lo} == exp, req, {hi, lo}, exp);
    @(negedge clk);
    chk(done == 1'b0, "R3", {63'b0, done}, 64'd0);
  endtask

  initial begin
    #(8 * 20000);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [63:0] held;
    // R1: reset state
    repeat (3) @(negedge clk);
    chk({busy, done, hi, lo} == '0, "R1", {hi, lo}, 64'd0);
    rst = 1'b0;
    @(negedge clk);
    chk({busy, done, hi, lo} == '0, "R1", {62'b0, busy, done}, 64'd0);

    // vector table
    for (int i = 0; i < NV; i++) begin
      run_op(VEC[i][65:64], VEC[i][63:32], VEC[i][31:0], 1'b0,
             tag_of(VEC[i][65:64], VEC[i][63:32], VEC[i][31:0]));
    end

    // R9: divide by zero in both modes
    run_op(2'b10, 32'hFFFFFFFB, 32'd0, 1'b0, "R9");
    run_op(2'b11, 32'd123,      32'd0, 1'b0, "R9");

    // R4: start while busy is ignored
    run_op(2'b01, 32'd1000, 32'd77, 1'b1, "R4");

    // R10: operand changes without start leave results untouched
    held = {hi, lo};
    op = 2'b11; a = 32'h55AA55AA; b = 32'h3;
    repeat (8) @(negedge clk);
    chk({hi, lo} == held, "R10", {hi, lo}, held);
    chk(busy == 1'b0 && done == 1'b0, "R10", {62'b0, busy, done}, 64'd0);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule